// File: doc/BRIEF.md
# Single-Wire Slave Reset and Slot Detector

This block is the slave-side front end of a single-wire bus. The bus is open-drain and idles high. The raw line is brought into the clock domain through a synchronizer. Each falling edge driven by the master is reported as the start of a time slot.

In parallel, a low-time counter advances on a free-running one-microsecond tick. When the line stays low past the limit for the current speed, the block emits a single bus-reset pulse. The limit is 120 µs at regular speed and 16 µs at overdrive speed.

The speed register is set to overdrive by a request pulse from the command layer. Any low period that exceeds the regular limit drops it back to regular speed. After a reset is detected, the block holds a reset condition until the line has been high for a short recovery window. During that condition slot starts are withheld and the open-drain pull-down request from the bit engine is blocked. Bit sampling, presence timing and command decoding sit downstream.

Top module: `ow_rst_det`

## Requirements
- R1: After `bus_i` falls, `slot_start_o` is high for exactly one clock cycle, in the third rising clock edge after the fall (two synchronizer stages plus an output register). There is one pulse per falling edge.
- R2: A low period that spans no more ticks of `us_tick_i` than the active limit produces no `reset_o`.
- R3: At regular speed, `reset_o` pulses when the line stays low for more than REG_RST_US (default 120) ticks. The low-time counter saturates and never wraps.
- R4: `reset_o` pulses at most once per low period, however long the line stays low.
- R5: At overdrive speed, `reset_o` pulses when the line stays low for more than OD_RST_US (default 16) ticks. Overdrive (`od_o`=1) is kept when that low period ends before the regular limit.
- R6: A one-cycle `od_set_i` pulse sets `od_o` to 1. A low period that exceeds the regular limit clears `od_o` to 0, at either speed.
- R7: From a detected reset until the line has been high for RECOV_US (default 8) consecutive ticks, falling edges produce no `slot_start_o`.
- R8: `pd_en_o` (1 = pull the line low) equals `pd_req_i`, except during the reset condition of R7, when it is 0.
- R9: After `rst_ni` is released, `slot_start_o`, `reset_o`, `pd_en_o` and `od_o` are all 0, and the speed is regular.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 1 | Raw single-wire line level |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| od_set_i | input | 1 | Request to enter overdrive speed |
| pd_req_i | input | 1 | Pull-down request from the bit engine |
| slot_start_o | output | 1 | Time slot start pulse |
| reset_o | output | 1 | Bus reset detected pulse |
| pd_en_o | output | 1 | Open-drain pull-down enable |
| od_o | output | 1 | 1 = overdrive speed active |

## Verification
The assertions check several properties on every cycle:
- slot and reset pulses last a single cycle;
- no slot start coincides with a reset;
- the pull-down is off when a reset is reported;
- the speed falls back to regular only while the line is low;
- the low-time counter saturates and never wraps.

The threshold boundaries need directed scenarios that hold the line low for chosen tick counts, at each speed. The same holds for the single reset pulse over a very long low, for overdrive being kept after a short reset, for slot suppression inside the recovery window, and for the exact three-cycle slot latency.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic {
    SPD_REG = 1'b0,
    SPD_OD  = 1'b1
  } ow_speed_e;
endpackage

// File: rtl/ow_sync_edge.sv
module ow_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign level_o = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= level_o;
  end

  assign fall_o = prev_q & ~level_o;
endmodule

// File: rtl/ow_low_timer.sv
module ow_low_timer #(
  parameter int REG_RST_US = 120,
  parameter int OD_RST_US  = 16,
  parameter int CNT_W      = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             level_i,
  input  logic             fall_i,
  input  logic             tick_i,
  input  logic             od_i,
  output logic             fire_o,
  output logic             reg_cross_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] REG_THR = CNT_W'(REG_RST_US);
  localparam logic [CNT_W-1:0] OD_THR  = CNT_W'(OD_RST_US);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic             step;
  logic [CNT_W-1:0] thr;

  assign step        = ~level_i & tick_i & ~fall_i;
  assign thr         = od_i ? OD_THR : REG_THR;
  assign fire_o      = step & ~fired_q & (cnt_q == thr);
  assign reg_cross_o = step & (cnt_q == REG_THR);
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (fall_i) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (step && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (fire_o) fired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ow_rst_guard.sv
module ow_rst_guard #(
  parameter int RECOV_US = 8,
  parameter int RCNT_W   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic level_i,
  input  logic tick_i,
  output logic active_o
);
  localparam logic [RCNT_W-1:0] REC_LAST = RCNT_W'(RECOV_US - 1);

  logic              active_q;
  logic [RCNT_W-1:0] rec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rec_q    <= '0;
    end else if (fire_i) begin
      active_q <= 1'b1;
      rec_q    <= '0;
    end else if (active_q) begin
      if (!level_i) begin
        rec_q <= '0;
      end else if (tick_i) begin
        if (rec_q == REC_LAST) begin
          active_q <= 1'b0;
          rec_q    <= '0;
        end else begin
          rec_q <= rec_q + 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/ow_rst_det.sv
module ow_rst_det #(
  parameter int SYNC_STAGES = 2,
  parameter int REG_RST_US  = 120,
  parameter int OD_RST_US   = 16,
  parameter int RECOV_US    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  input  logic us_tick_i,
  input  logic od_set_i,
  input  logic pd_req_i,
  output logic slot_start_o,
  output logic reset_o,
  output logic pd_en_o,
  output logic od_o
);
  import ow_pkg::*;

  localparam int CNT_W  = $clog2(REG_RST_US + 2);
  localparam int RCNT_W = $clog2(RECOV_US + 1);

  logic             bus_s;
  logic             bus_fall;
  logic             fire;
  logic             reg_cross;
  logic             rst_active;
  logic [CNT_W-1:0] low_cnt;
  logic             slot_q;
  logic             rst_q;
  ow_speed_e        speed_q;

  ow_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (bus_i),
    .level_o (bus_s),
    .fall_o  (bus_fall)
  );

  ow_low_timer #(
    .REG_RST_US (REG_RST_US),
    .OD_RST_US  (OD_RST_US),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .level_i     (bus_s),
    .fall_i      (bus_fall),
    .tick_i      (us_tick_i),
    .od_i        (speed_q == SPD_OD),
    .fire_o      (fire),
    .reg_cross_o (reg_cross),
    .cnt_o       (low_cnt)
  );

  ow_rst_guard #(
    .RECOV_US (RECOV_US),
    .RCNT_W   (RCNT_W)
  ) u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .level_i  (bus_s),
    .tick_i   (us_tick_i),
    .active_o (rst_active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= 1'b0;
      rst_q   <= 1'b0;
      speed_q <= SPD_REG;
    end else begin
      slot_q <= bus_fall & ~rst_active;
      rst_q  <= fire;
      if (reg_cross)     speed_q <= SPD_REG;
      else if (od_set_i) speed_q <= SPD_OD;
    end
  end

  assign slot_start_o = slot_q;
  assign reset_o      = rst_q;
  assign od_o         = (speed_q == SPD_OD);
  assign pd_en_o      = pd_req_i & ~rst_active;
endmodule

// File: rtl/ow_rst_det_chk.sv
module ow_rst_det_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             slot_start_o,
  input logic             reset_o,
  input logic             pd_en_o,
  input logic             od_o,
  input logic             bus_s,
  input logic [CNT_W-1:0] low_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_slot_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_o |=> !slot_start_o);

  p_rst_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |=> !reset_o);

  p_no_slot_at_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> !slot_start_o);

  p_pd_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> !pd_en_o);

  p_od_drop_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(od_o) |-> !$past(bus_s));

  p_cnt_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(low_cnt) == CNT_MAX) |-> (low_cnt == CNT_MAX || low_cnt == '0));
endmodule

bind ow_rst_det ow_rst_det_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slot_start_o (slot_start_o),
  .reset_o      (reset_o),
  .pd_en_o      (pd_en_o),
  .od_o         (od_o),
  .bus_s        (bus_s),
  .low_cnt      (low_cnt)
);

// File: tb/ow_rst_det_tb.sv
`timescale 1ns/1ps
module ow_rst_det_tb;
  localparam int TDIV   = 4;
  localparam int REG_US = 120;
  localparam int OD_US  = 16;
  localparam int REC_US = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus = 1'b1;
  logic us_tick = 1'b0;
  logic od_set = 1'b0;
  logic pd_req = 1'b0;
  logic slot_start, reset_p, pd_en, od;

  int n_chk = 0;
  int n_bad = 0;
  int n_slot = 0;
  int n_rst = 0;
  int tdiv = 0;

  always #2.5 clk = ~clk;

  ow_rst_det u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bus_i        (bus),
    .us_tick_i    (us_tick),
    .od_set_i     (od_set),
    .pd_req_i     (pd_req),
    .slot_start_o (slot_start),
    .reset_o      (reset_p),
    .pd_en_o      (pd_en),
    .od_o         (od)
  );

  always @(negedge clk) begin
    tdiv    = (tdiv + 1) % TDIV;
    us_tick = (tdiv == 0);
  end

  always @(posedge clk) begin
    if (rst_n && slot_start) n_slot++;
    if (rst_n && reset_p)    n_rst++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic low_pulse(input int ticks, input int settle);
    @(negedge clk);
    bus = 1'b0;
    wait_ticks(ticks);
    bus = 1'b1;
    wait_ticks(settle);
  endtask

  task automatic t_reset_state;
    check(slot_start == 1'b0, "R9 slot", slot_start, 0);
    check(reset_p == 1'b0, "R9 reset", reset_p, 0);
    check(pd_en == 1'b0, "R9 pd", pd_en, 0);
    check(od == 1'b0, "R9 od", od, 0);
  endtask

  task automatic t_latency;
    int s0;
    s0 = n_slot;
    @(negedge clk);
    bus = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check(slot_start == 1'b0, "R1 early", slot_start, 0);
    @(posedge clk); #1;
    check(slot_start == 1'b1, "R1 third edge", slot_start, 1);
    @(posedge clk); #1;
    check(slot_start == 1'b0, "R1 one cycle", slot_start, 0);
    wait_ticks(5);
    bus = 1'b1;
    wait_ticks(3);
    check(n_slot == s0 + 1, "R1 count", n_slot, s0 + 1);
  endtask

  task automatic t_short_slots;
    int s0, r0;
    s0 = n_slot; r0 = n_rst;
    for (int i = 0; i < 5; i++) low_pulse(10 + 20 * i, 3);
    check(n_slot == s0 + 5, "R1 slots", n_slot, s0 + 5);
    check(n_rst == r0, "R2 no reset short", n_rst, r0);
  endtask

  task automatic t_regular_reset;
    int r0, s0;
    r0 = n_rst;
    low_pulse(REG_US - 2, 3);
    check(n_rst == r0, "R2 below regular limit", n_rst, r0);
    r0 = n_rst;
    low_pulse(REG_US + 3, REC_US + 3);
    check(n_rst == r0 + 1, "R3 regular reset", n_rst, r0 + 1);
    r0 = n_rst; s0 = n_slot;
    low_pulse(200, REC_US + 3);
    check(n_rst == r0 + 1, "R4 single reset long low", n_rst, r0 + 1);
    check(n_slot == s0 + 1, "R3 slot after saturation", n_slot, s0 + 1);
  endtask

  task automatic t_overdrive;
    int r0;
    @(negedge clk); od_set = 1'b1;
    @(negedge clk); od_set = 1'b0;
    check(od == 1'b1, "R6 enter overdrive", od, 1);
    r0 = n_rst;
    low_pulse(OD_US - 2, 3);
    check(n_rst == r0, "R2 below overdrive limit", n_rst, r0);
    low_pulse(OD_US + 4, REC_US + 3);
    check(n_rst == r0 + 1, "R5 overdrive reset", n_rst, r0 + 1);
    check(od == 1'b1, "R5 overdrive kept", od, 1);
    r0 = n_rst;
    low_pulse(REG_US + 10, REC_US + 3);
    check(n_rst == r0 + 1, "R4 one reset in overdrive long low", n_rst, r0 + 1);
    check(od == 1'b0, "R6 back to regular", od, 0);
  endtask

  task automatic t_recovery;
    int s0;
    low_pulse(REG_US + 3, 2);
    s0 = n_slot;
    low_pulse(1, 2);
    check(n_slot == s0, "R7 slot suppressed", n_slot, s0);
    wait_ticks(REC_US + 3);
    low_pulse(2, 3);
    check(n_slot == s0 + 1, "R7 slot after recovery", n_slot, s0 + 1);
  endtask

  task automatic t_pulldown;
    @(negedge clk); pd_req = 1'b1;
    @(negedge clk);
    check(pd_en == 1'b1, "R8 follows request", pd_en, 1);
    bus = 1'b0;
    wait_ticks(REG_US + 4);
    check(pd_en == 1'b0, "R8 blocked in reset", pd_en, 0);
    bus = 1'b1;
    wait_ticks(2);
    check(pd_en == 1'b0, "R8 blocked in recovery", pd_en, 0);
    wait_ticks(REC_US + 2);
    check(pd_en == 1'b1, "R8 restored", pd_en, 1);
    pd_req = 1'b0;
    @(negedge clk);
    check(pd_en == 1'b0, "R8 request dropped", pd_en, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state;
    t_latency;
    t_short_slots;
    t_regular_reset;
    t_overdrive;
    t_recovery;
    t_pulldown;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule